// File: doc/BRIEF.md
# Synchronous Bus Read/Write Master

This unit sits on the processor side of a synchronous, clocked memory bus. It takes one command at a time from a ready/valid port. A command carries a start address, a direction flag, write data and a word count. The unit turns each command into a bus cycle made of three clock states. In the first state it drives the address. Half a clock later it lowers an active-low memory strobe and, for reads, an active-low read strobe. In the third state it samples the read data on the falling clock edge.

When the word count is two or more, the unit keeps the strobes low after the first word. It then moves one further word per clock and steps the address up by one for each word. A single word therefore costs three bus clocks, and every word after the first in a block costs one. Read words come back on a response port as one-cycle pulses.

For a write, the first data word is taken with the command. Each later word of a block write is pulled from the same data input: a take signal marks every rising edge on which a word is consumed. The address always settles half a clock before the memory strobe falls, so that a memory which begins a write on the strobe never sees an unsettled address.

Top module: `sync_bus_master`

## Requirements
- R1: While reset is held and after it is released with no command, cmd_ready is 1, bus_mreq_n and bus_rd_n are 1, rsp_valid is 0 and bus_dout_en is 0.
- R2: A command is accepted on a rising edge where cmd_valid and cmd_ready are both 1. cmd_ready is 0 from the next cycle until the last data cycle of the transfer has ended. It returns to 1 in the cycle after that last data cycle, which is cycle n+3 when cycle 1 is the first cycle after acceptance and n is the word count.
- R3: The start address appears on bus_addr at the rising edge that begins cycle 1 (state T1), while bus_mreq_n is still 1. bus_mreq_n falls only at the falling edge inside cycle 1, never before the address is driven. The address holds through cycles 1 to 3.
- R4: For a read, bus_rd_n is 0 on exactly the same falling edges as bus_mreq_n. For a write, bus_rd_n stays 1 throughout.
- R5: A cmd_len of 0 or 1 is a single transfer. The strobes are low for the falling edges of cycles 1, 2 and 3 only, and return to 1 at the falling edge of cycle 4.
- R6: Read data on bus_din are sampled at the falling edge of each data cycle. Word k (counting from 0) is sampled in cycle 3+k. Word k is presented on rsp_data with a one-cycle rsp_valid pulse in cycle 4+k.
- R7: A cmd_len of n >= 2 is a block transfer. Word k >= 1 occupies cycle 3+k alone. bus_addr in that cycle is the start address plus k, wrapping modulo 2^ADDR_W. The strobes stay low for the falling edges of cycles 1 to n+2.
- R8: A write drives bus_dout_en at 1 from cycle 1 to cycle n+2. Word 0 is cmd_wdata at acceptance and is on bus_dout in cycles 1 to 3. Word k >= 1 is the cmd_wdata value at the k-th further rising edge with wdata_take at 1, and is on bus_dout in cycle 3+k. wdata_take is 1 on exactly n edges per write. rsp_valid stays 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to accept a command |
| cmd_addr | input | ADDR_W | Start address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data word (first word with the command, later words on wdata_take) |
| cmd_len | input | LEN_W | Word count; 0 and 1 both mean one word |
| wdata_take | output | 1 | cmd_wdata is consumed at this rising edge |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data holds a read word |
| rsp_data | output | DATA_W | Read word |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_mreq_n | output | 1 | Active-low memory request strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_dout | output | DATA_W | Write data lines |
| bus_dout_en | output | 1 | Write data lines driven |
| bus_din | input | DATA_W | Read data lines |

## Verification
Every result is due on a fixed cycle counted from the accepting edge. The address and write word are due at the rising edge of cycles 1 to 3 and 3+k. The strobes are due at the falling edge of cycles 1 to n+2 and go high at cycle n+3. Read word k is due at the rising edge that opens cycle 4+k, and cmd_ready at the edge that opens cycle n+3. The bench walks every cycle of each transfer. It samples 1 ns after each rising edge and 1 ns after each falling edge, and compares against the position computed from the word count. It sweeps every cmd_len value for reads and for writes, including blocks that wrap past the top address, and reads back every written region through the bus.

// File: rtl/sync_bus_pkg.sv
`timescale 1ns/1ps
package sync_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_BLK  = 3'd4
  } bus_state_e;

  // Number of words moved for a given length field (0 counts as one word).
  function automatic int unsigned words_in(input int unsigned len_v);
    return (len_v == 0) ? 1 : len_v;
  endfunction

  // Cycle (1 = first after acceptance) in which word k is on the bus.
  function automatic int unsigned word_cycle(input int unsigned k);
    return 3 + k;
  endfunction

endpackage

// File: rtl/sync_bus_seq.sv
`timescale 1ns/1ps
module sync_bus_seq
  import sync_bus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              wdata_take,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              write_o,
  output logic              active_o,
  output logic              data_phase_o
);

  bus_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic [LEN_W-1:0]  left_q;

  // Named events used by the logic and the assertions.
  logic accept_ev;
  logic more_ev;
  logic data_phase;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign accept_ev  = cmd_valid && cmd_ready;
  assign data_phase = (state_q == ST_T3) || (state_q == ST_BLK);
  assign more_ev    = data_phase && (left_q != '0);
  assign wdata_take = (accept_ev && cmd_write) || (more_ev && write_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_ev) begin
            addr_q  <= cmd_addr;
            write_q <= cmd_write;
            left_q  <= LEN_W'(words_in(32'(cmd_len)) - 1);
            if (cmd_write) wdata_q <= cmd_wdata;
            state_q <= ST_T1;
          end
        end
        ST_T1: state_q <= ST_T2;
        ST_T2: state_q <= ST_T3;
        ST_T3, ST_BLK: begin
          if (more_ev) begin
            addr_q  <= addr_q + 1'b1;
            left_q  <= left_q - 1'b1;
            if (write_q) wdata_q <= cmd_wdata;
            state_q <= ST_BLK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o       = addr_q;
  assign wdata_o      = wdata_q;
  assign write_o      = write_q;
  assign active_o     = (state_q != ST_IDLE);
  assign data_phase_o = data_phase;

  // R2: after an accept the port is busy on the next edge
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !cmd_ready);

  // R3: address holds through the three states of the first word
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T2 || state_q == ST_T3) |-> $stable(addr_q));

  // R7: each block cycle carries the next address
  assert_block_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLK) |-> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

endmodule

// File: rtl/sync_bus_strobe.sv
`timescale 1ns/1ps
module sync_bus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic write,
  output logic mreq_n,
  output logic rd_n
);

  // Strobes change on the falling edge, half a clock after the address.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreq_n <= 1'b1;
      rd_n   <= 1'b1;
    end else begin
      mreq_n <= !active;
      rd_n   <= !(active && !write);
    end
  end

  // R4: read strobe is never low without the memory strobe
  assert_rd_with_mreq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mreq_n);

endmodule

// File: rtl/sync_bus_capture.sv
`timescale 1ns/1ps
module sync_bus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] bus_din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] cap_q;

  // Sample at the falling edge of the data cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)         cap_q <= '0;
    else if (sample_en) cap_q <= bus_din;
  end

  // Republish at the rising edge that closes the data cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample_en;
      if (sample_en) rsp_data <= cap_q;
    end
  end

  // R6: a response follows exactly one sampling cycle
  assert_rsp_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(sample_en));

endmodule

// File: rtl/sync_bus_master.sv
`timescale 1ns/1ps
module sync_bus_master #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              wdata_take,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_mreq_n,
  output logic              bus_rd_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din
);

  logic seq_write;
  logic seq_active;
  logic seq_data_phase;
  logic read_sample;

  sync_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_addr     (cmd_addr),
    .cmd_write    (cmd_write),
    .cmd_wdata    (cmd_wdata),
    .cmd_len      (cmd_len),
    .wdata_take   (wdata_take),
    .addr_o       (bus_addr),
    .wdata_o      (bus_dout),
    .write_o      (seq_write),
    .active_o     (seq_active),
    .data_phase_o (seq_data_phase)
  );

  sync_bus_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (seq_active),
    .write  (seq_write),
    .mreq_n (bus_mreq_n),
    .rd_n   (bus_rd_n)
  );

  assign read_sample = seq_data_phase && !seq_write;

  sync_bus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (read_sample),
    .bus_din   (bus_din),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign bus_dout_en = seq_active && seq_write;

  // R3: the memory strobe only falls in the cycle after an accepted command
  assert_strobe_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_mreq_n) |-> $past(cmd_valid && cmd_ready));

  // R8: write data lines are never driven while the read strobe is low
  assert_dout_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> bus_rd_n);

  // R8: writes never produce a response
  assert_no_rsp_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !bus_mreq_n) |-> !bus_dout_en);

endmodule

// File: tb/sync_bus_master_tb.sv
`timescale 1ns/1ps
module sync_bus_master_tb;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata;
  logic [LW-1:0] cmd_len = '0;
  logic          wdata_take;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic          bus_mreq_n;
  logic          bus_rd_n;
  logic [DW-1:0] bus_dout;
  logic          bus_dout_en;
  logic [DW-1:0] bus_din;

  int n_chk = 0;
  int n_bad = 0;
  int take_idx = 0;
  int exp_takes = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem    [256];
  logic [DW-1:0] shadow [256];

  always #2.5 clk = ~clk;

  sync_bus_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .cmd_len(cmd_len), .wdata_take(wdata_take), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_addr(bus_addr), .bus_mreq_n(bus_mreq_n),
    .bus_rd_n(bus_rd_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din)
  );

  function automatic logic [DW-1:0] init_pat(input int a);
    return DW'(a) ^ 8'h5A;
  endfunction

  function automatic logic [DW-1:0] wpat(input int i);
    return DW'(i * 37 + 5);
  endfunction

  // Memory model: zero-latency read, write committed on rising edges.
  assign bus_din   = bus_rd_n ? 8'hEE : mem[bus_addr];
  assign cmd_wdata = wpat(take_idx);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_pat(i);
    end else if (!bus_mreq_n && bus_rd_n && bus_dout_en) begin
      mem[bus_addr] <= bus_dout;
    end
  end

  // Write-data feeder: advance the word after every edge that takes one.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (wdata_take) begin
        @(posedge clk);
        #1;
        take_idx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic xfer(input int addr, input bit wr, input int len);
    int n;
    int idx0;
    int off;
    n = (len == 0) ? 1 : len;
    @(negedge clk);
    idx0      = take_idx;
    cmd_addr  = AW'(addr);
    cmd_write = wr;
    cmd_len   = LW'(len);
    cmd_valid = 1'b1;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    if (wr) exp_takes += n;
    for (int c = 1; c <= n + 3; c++) begin
      if (c > 1) begin
        @(posedge clk);
        #1;
      end
      off = (c <= 3) ? 0 : c - 3;
      chk(cmd_ready == (c == n + 3), "R2 ready", cmd_ready, c == n + 3);
      if (c == 1) chk(bus_mreq_n == 1'b1, "R3 strobe late", bus_mreq_n, 1);
      if (c <= n + 2) begin
        chk(bus_addr == AW'(addr + off), "R7 addr", bus_addr, AW'(addr + off));
        if (wr) begin
          chk(bus_dout_en == 1'b1, "R8 dout_en", bus_dout_en, 1);
          chk(bus_dout == wpat(idx0 + off), "R8 dout", bus_dout, wpat(idx0 + off));
        end
      end
      if (!wr && c >= 4) begin
        chk(rsp_valid == 1'b1, "R6 rsp_valid", rsp_valid, 1);
        chk(rsp_data == shadow[(addr + c - 4) % 256], "R6 rsp_data", rsp_data,
            shadow[(addr + c - 4) % 256]);
      end else begin
        chk(rsp_valid == 1'b0, "R8 no rsp", rsp_valid, 0);
      end
      @(negedge clk);
      #1;
      chk(bus_mreq_n == !(c <= n + 2), "R5 mreq", bus_mreq_n, !(c <= n + 2));
      chk(bus_rd_n == !(!wr && c <= n + 2), "R4 rd", bus_rd_n, !(!wr && c <= n + 2));
    end
    if (wr) begin
      for (int k = 0; k < n; k++) shadow[(addr + k) % 256] = wpat(idx0 + k);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = init_pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(cmd_ready == 1'b1 && bus_mreq_n && bus_rd_n && !rsp_valid && !bus_dout_en,
        "R1 in reset", {cmd_ready, bus_mreq_n, bus_rd_n, rsp_valid, bus_dout_en}, 5'b11100);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(cmd_ready == 1'b1 && bus_mreq_n && bus_rd_n && !rsp_valid && !bus_dout_en,
        "R1 after reset", {cmd_ready, bus_mreq_n, bus_rd_n, rsp_valid, bus_dout_en}, 5'b11100);

    // Single transfers (R5): edges of the address range, both length codes.
    xfer(0, 1'b0, 0);
    xfer(255, 1'b0, 1);
    xfer(0, 1'b1, 1);
    xfer(255, 1'b1, 0);
    xfer(0, 1'b0, 1);
    xfer(255, 1'b0, 0);

    // Block reads for every length (R7), the longest wraps past 255.
    for (int l = 0; l < 16; l++) xfer(l * 17, 1'b0, l);
    // Block writes for every length, then read each region back (R8).
    for (int l = 0; l < 16; l++) xfer((240 + l * 5) % 256, 1'b1, l);
    for (int l = 0; l < 16; l++) xfer((240 + l * 5) % 256, 1'b0, l);

    repeat (3) @(posedge clk);
    #1;
    chk(take_idx == exp_takes, "R8 take count", take_idx, exp_takes);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule